// File: doc/BRIEF.md
# Fault Status and Interrupt Register Bank

This block holds the fault record of a power or lighting controller and turns it into one interrupt line. Detection logic elsewhere pulses one event input per fault source. Each pulse sets a sticky status bit. Each source also has its own 2-bit interrupt-enable field, and a global enable field sits above all of them. The active-low interrupt output is driven low while any enabled status bit is set and the global enable is on.

Host firmware reaches the bank through a plain register port: a byte address, write data, a write strobe and registered read data. Each status bit has a companion clear bit one position below it. A fault is dismissed only when one write sets both bits of its pair to 1. Enable fields are read back in a different code from the one used to write them. The top source stands for a group of output channels. Per-channel open and short flags sit in their own read-only word, and they clear together with that parent status bit.

Top module: `fault_irq_regbank`

## Requirements
- R1: After a synchronous reset the bank is in this state: every status bit and every channel flag is 0, the global enable is on, `irq_n` is 1 and `rdata` is 0. Each source enable takes its value from parameter `EN_RST`. By default all sources are enabled except sources 1 and 2.
- R2: Register layout, by byte address.
  - 0x00 (status word): source k has its status at bit 2k+1 and its clear at bit 2k. Clear bits always read 0.
  - 0x02 (enable word): holds the enable field of source k at bits [2k+1:2k].
  - 0x04 (channel word): holds the open flags at bits [N_CH-1:0] and the short flags at bits [2*N_CH-1:N_CH].
  - 0x06 (global enable): holds its field at bits [1:0].
- R3: A high event input sets its status bit at the next clock edge. The bit stays set after the event is removed, until it is cleared.
- R4: A status bit clears only when a single write to 0x00 has 1 in both its status bit and its clear bit. A write with only one of the two bits set leaves the status bit unchanged.
- R5: If a source's event is high in the same cycle as its clear write, the status bit stays set.
- R6: An enable field reads 2 when enabled and 0 when disabled. Writing code 3 enables it and writing code 1 disables it. Writing code 0 or 2 leaves it unchanged. The global enable field follows the same rules.
- R7: Each channel open or short event sets its own flag and also sets the top source status bit (index N_GEN). Writes to 0x04 have no effect. A clear of the top source pair clears all channel flags, except any flag whose event is present in that cycle.
- R8: `irq_n` is registered. One cycle after the state is updated, it is 0 exactly when the global enable is on and some status bit with its own enable on is set. Otherwise it is 1.
- R9: `rdata` is registered. It shows the addressed word as it stood before the clock edge that captures the read.
- R10: Any other address, including odd addresses, reads 0. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe, one cycle per write |
| fault_evt | input | N_GEN | Event input for each generic fault source |
| chan_open_evt | input | N_CH | Open-condition event for each channel |
| chan_short_evt | input | N_CH | Short-condition event for each channel |
| rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `rst` is held for at least one rising edge before any check counts. They also assume that event inputs are sampled as levels, so a held event acts as a repeated set. The stimulus meets these assumptions by changing every input only on the falling clock edge and by starting each run with a reset. The channel-to-parent invariant assumes that channel events enter the bank only through their own ports. The bench therefore never forces internal state: channel flags are reached only through events, writes and parent clears.

// File: rtl/fault_bank_pkg.sv
package fault_bank_pkg;
  // write commands for an enable field
  localparam logic [1:0] EN_CMD_OFF = 2'b01;
  localparam logic [1:0] EN_CMD_ON  = 2'b11;
  // read-back codes of an enable field
  localparam logic [1:0] EN_RD_ON   = 2'b10;
  localparam logic [1:0] EN_RD_OFF  = 2'b00;

  typedef enum logic [1:0] {
    W_STATUS = 2'd0,
    W_ENABLE = 2'd1,
    W_CHAN   = 2'd2,
    W_GLOBAL = 2'd3
  } word_e;
endpackage

// File: rtl/fault_sticky_bit.sv
module fault_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R3: a set bit stays set unless cleared
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    q_o && !clr_i |=> q_o);
  // R5: a present event always wins
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R4: a clear without an event removes the bit
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
    clr_i && !set_i |=> !q_o);
endmodule

// File: rtl/irq_en_field.sv
module irq_en_field
  import fault_bank_pkg::*;
#(
  parameter bit RST_ON = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  output logic       on_o
);
  always_ff @(posedge clk) begin
    if (rst)                              on_o <= RST_ON;
    else if (wr_i && code_i == EN_CMD_ON)  on_o <= 1'b1;
    else if (wr_i && code_i == EN_CMD_OFF) on_o <= 1'b0;
  end

  // R6: command 3 enables, command 1 disables, 0 and 2 hold
  a_r6_cmd_on: assert property (@(posedge clk) disable iff (rst)
    wr_i && code_i == 2'b11 |=> on_o);
  a_r6_cmd_off: assert property (@(posedge clk) disable iff (rst)
    wr_i && code_i == 2'b01 |=> !on_o);
  a_r6_no_cmd_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && code_i[0]) |=> $stable(on_o));
endmodule

// File: rtl/fault_irq_regbank.sv
module fault_irq_regbank
  import fault_bank_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int N_GEN  = 7,
  parameter int N_CH   = 4,
  parameter logic [N_GEN:0] EN_RST = 8'hF9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [N_GEN-1:0]  fault_evt,
  input  logic [N_CH-1:0]   chan_open_evt,
  input  logic [N_CH-1:0]   chan_short_evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);
  localparam int N_SRC  = N_GEN + 1;
  localparam int PARENT = N_GEN;

  logic              hit;
  word_e             word;
  logic              wr_status, wr_enable, wr_global;
  logic [N_SRC-1:0]  set_vec, clr_vec, status, en_on;
  logic [N_CH-1:0]   open_q, short_q;
  logic              glob_on;
  logic [DATA_W-1:0] rd_word;

  // address decode: even byte offsets 0x00..0x06 only
  assign hit       = (addr[0] == 1'b0) && (addr[ADDR_W-1:3] == '0);
  assign word      = word_e'(addr[2:1]);
  assign wr_status = we && hit && (word == W_STATUS);
  assign wr_enable = we && hit && (word == W_ENABLE);
  assign wr_global = we && hit && (word == W_GLOBAL);

  assign set_vec = {(|chan_open_evt) | (|chan_short_evt), fault_evt};

  generate
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
      assign clr_vec[k] = wr_status && wdata[2*k+1] && wdata[2*k];

      fault_sticky_bit u_stat (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_vec[k]),
        .clr_i(clr_vec[k]),
        .q_o  (status[k])
      );

      irq_en_field #(.RST_ON(EN_RST[k])) u_en (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr_enable),
        .code_i(wdata[2*k+1:2*k]),
        .on_o  (en_on[k])
      );
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      fault_sticky_bit u_open (
        .clk  (clk),
        .rst  (rst),
        .set_i(chan_open_evt[c]),
        .clr_i(clr_vec[PARENT]),
        .q_o  (open_q[c])
      );
      fault_sticky_bit u_short (
        .clk  (clk),
        .rst  (rst),
        .set_i(chan_short_evt[c]),
        .clr_i(clr_vec[PARENT]),
        .q_o  (short_q[c])
      );
    end
  endgenerate

  irq_en_field #(.RST_ON(1'b1)) u_glob (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (wr_global),
    .code_i(wdata[1:0]),
    .on_o  (glob_on)
  );

  // read multiplexer
  always_comb begin
    rd_word = '0;
    if (hit) begin
      case (word)
        W_STATUS: for (int k = 0; k < N_SRC; k++) rd_word[2*k+1] = status[k];
        W_ENABLE: for (int k = 0; k < N_SRC; k++)
                    rd_word[2*k +: 2] = en_on[k] ? EN_RD_ON : EN_RD_OFF;
        W_CHAN: begin
          rd_word[N_CH-1:0]      = open_q;
          rd_word[2*N_CH-1:N_CH] = short_q;
        end
        W_GLOBAL: rd_word[1:0] = glob_on ? EN_RD_ON : EN_RD_OFF;
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_n <= 1'b1;
    end else begin
      rdata <= rd_word;
      irq_n <= !(glob_on && |(status & en_on));
    end
  end

  // R8: global enable off keeps the line released
  a_r8_global_gate: assert property (@(posedge clk) disable iff (rst)
    !glob_on |=> irq_n);
  // R8: an enabled pending fault pulls the line low
  a_r8_pending_asserts: assert property (@(posedge clk) disable iff (rst)
    glob_on && |(status & en_on) |=> !irq_n);
  // R7: a channel flag never outlives its parent status
  a_r7_parent_covers: assert property (@(posedge clk) disable iff (rst)
    |{open_q, short_q} |-> status[PARENT]);
  // R10: reserved-address writes leave the enables alone
  a_r10_reserved_write: assert property (@(posedge clk) disable iff (rst)
    we && !hit |=> $stable(en_on) && $stable(glob_on));
endmodule

// File: tb/fault_irq_regbank_bench.sv
module fault_irq_regbank_bench;
  localparam int ADDR_W = 5;
  localparam int DW     = 16;
  localparam int N_GEN  = 7;
  localparam int N_CH   = 4;
  localparam int N_SRC  = N_GEN + 1;
  localparam logic [N_SRC-1:0] EN_RST = 8'hF9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0;
  logic [N_GEN-1:0] fevt = '0;
  logic [N_CH-1:0] oevt = '0, sevt = '0;
  logic [DW-1:0] rdata;
  logic irq_n;

  always #5 clk = ~clk;

  fault_irq_regbank u_fault_irq_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .fault_evt(fevt), .chan_open_evt(oevt), .chan_short_evt(sevt),
    .rdata(rdata), .irq_n(irq_n)
  );

  // behavioural reference state
  bit [N_SRC-1:0] m_stat, m_en;
  bit m_glob;
  bit [N_CH-1:0] m_open, m_short;
  logic [DW-1:0] e_rdata;
  logic e_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [DW-1:0] model_read(input logic [ADDR_W-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a[0] == 1'b0 && a[4:3] == 2'b00) begin
      case (a[2:1])
        2'd0: for (int k = 0; k < N_SRC; k++) r[2*k+1] = m_stat[k];
        2'd1: for (int k = 0; k < N_SRC; k++) r[2*k+1] = m_en[k];
        2'd2: begin r[3:0] = m_open; r[7:4] = m_short; end
        default: r[1] = m_glob;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input string req, input bit r, input logic [ADDR_W-1:0] a,
                      input logic [DW-1:0] w, input bit wr, input logic [N_GEN-1:0] f,
                      input logic [N_CH-1:0] o, input logic [N_CH-1:0] s);
    bit hit, pclr, clr, st;
    logic [1:0] code;
    rst = r; addr = a; wdata = w; we = wr; fevt = f; oevt = o; sevt = s;
    if (r) begin
      e_rdata = '0; e_irq = 1'b1;
      m_stat = '0; m_en = EN_RST; m_glob = 1'b1; m_open = '0; m_short = '0;
    end else begin
      e_rdata = model_read(a);
      e_irq = !(m_glob && |(m_stat & m_en));
      hit = (a[0] == 1'b0) && (a[4:3] == 2'b00);
      pclr = wr && hit && a[2:1] == 2'd0 && w[2*N_GEN+1] && w[2*N_GEN];
      for (int k = 0; k < N_SRC; k++) begin
        clr = wr && hit && a[2:1] == 2'd0 && w[2*k+1] && w[2*k];
        st = (k < N_GEN) ? f[k] : ((|o) || (|s));
        if (st) m_stat[k] = 1'b1;
        else if (clr) m_stat[k] = 1'b0;
      end
      for (int c = 0; c < N_CH; c++) begin
        if (o[c]) m_open[c] = 1'b1; else if (pclr) m_open[c] = 1'b0;
        if (s[c]) m_short[c] = 1'b1; else if (pclr) m_short[c] = 1'b0;
      end
      if (wr && hit && a[2:1] == 2'd1)
        for (int k = 0; k < N_SRC; k++) begin
          code = w[2*k +: 2];
          if (code == 2'b01) m_en[k] = 1'b0;
          else if (code == 2'b11) m_en[k] = 1'b1;
        end
      if (wr && hit && a[2:1] == 2'd3) begin
        if (w[1:0] == 2'b01) m_glob = 1'b0;
        else if (w[1:0] == 2'b11) m_glob = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, rdata, e_rdata, "rdata");
    check(req, {15'd0, irq_n}, {15'd0, e_irq}, "irq_n");
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a);
    tick(req, 0, a, '0, 0, '0, '0, '0);
  endtask

  task automatic wr(input string req, input logic [ADDR_W-1:0] a, input logic [DW-1:0] w);
    tick(req, 0, a, w, 1, '0, '0, '0);
  endtask

  initial begin
    // R1: reset state of every word
    tick("R1", 1, '0, '0, 0, '0, '0, '0);
    tick("R1", 1, '0, '0, 0, '0, '0, '0);
    rd("R1", 5'h00); rd("R1", 5'h02); rd("R1", 5'h04); rd("R1", 5'h06);
    // R2: enable word layout, global word layout
    rd("R2", 5'h02); rd("R2", 5'h06);
    // R3: one-cycle event on source 0 is kept
    tick("R3", 0, 5'h00, '0, 0, 7'h01, '0, '0);
    rd("R3", 5'h00); rd("R3", 5'h00); rd("R3", 5'h00);
    // R4: lone status bit or lone clear bit does nothing; pair clears
    wr("R4", 5'h00, 16'h0002); rd("R4", 5'h00);
    wr("R4", 5'h00, 16'h0001); rd("R4", 5'h00);
    wr("R4", 5'h00, 16'h000C); rd("R4", 5'h00);
    wr("R4", 5'h00, 16'h0003); rd("R4", 5'h00); rd("R4", 5'h00);
    // R5: event held through the clear write keeps the bit
    tick("R5", 0, 5'h00, '0, 0, 7'h08, '0, '0);
    tick("R5", 0, 5'h00, 16'h00C0, 1, 7'h08, '0, '0);
    rd("R5", 5'h00);
    wr("R5", 5'h00, 16'h00C0); rd("R5", 5'h00);
    // R8: disabled source 1 keeps the line released, enabled one pulls it
    tick("R8", 0, 5'h00, '0, 0, 7'h02, '0, '0);
    rd("R8", 5'h00); rd("R8", 5'h00);
    tick("R8", 0, 5'h00, '0, 0, 7'h10, '0, '0);
    rd("R8", 5'h00); rd("R8", 5'h00);
    wr("R8", 5'h06, 16'h0001); rd("R8", 5'h06); rd("R8", 5'h06);
    wr("R8", 5'h06, 16'h0002); rd("R8", 5'h06);
    wr("R8", 5'h06, 16'h0003); rd("R8", 5'h06); rd("R8", 5'h00);
    // R6: enable commands 1, 3, 0 and 2
    wr("R6", 5'h02, 16'h0300); rd("R6", 5'h02);
    wr("R6", 5'h02, 16'h000C); rd("R6", 5'h02);
    wr("R6", 5'h02, 16'h0100); rd("R6", 5'h02);
    wr("R6", 5'h02, 16'hAA00); rd("R6", 5'h02);
    wr("R6", 5'h02, 16'h0000); rd("R6", 5'h02);
    wr("R6", 5'h02, 16'h5555); rd("R6", 5'h02); rd("R6", 5'h00);
    wr("R6", 5'h02, 16'hFFFF); rd("R6", 5'h02); rd("R6", 5'h00);
    // R7: channel flags, read-only word, parent clear
    tick("R7", 0, 5'h04, '0, 0, '0, 4'b0100, '0);
    tick("R7", 0, 5'h04, '0, 0, '0, '0, 4'b0001);
    rd("R7", 5'h04); rd("R7", 5'h00);
    wr("R7", 5'h04, 16'h0000); rd("R7", 5'h04);
    wr("R7", 5'h04, 16'hFFFF); rd("R7", 5'h04);
    tick("R7", 0, 5'h00, 16'hC000, 1, '0, 4'b1000, '0);
    rd("R7", 5'h04); rd("R7", 5'h00);
    wr("R7", 5'h00, 16'hC000); rd("R7", 5'h04); rd("R7", 5'h00);
    // R10: reserved and odd addresses
    wr("R10", 5'h08, 16'hFFFF); rd("R10", 5'h08);
    wr("R10", 5'h03, 16'h5555); rd("R10", 5'h03); rd("R10", 5'h02);
    wr("R10", 5'h07, 16'h0001); rd("R10", 5'h06); rd("R10", 5'h1E);
    wr("R10", 5'h01, 16'hFFFF); rd("R10", 5'h00);
    // R9: mixed random traffic, read timing checked every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [ADDR_W-1:0] ra;
      logic [N_GEN-1:0] rf;
      ra = ($urandom_range(0, 9) == 0) ? 5'($urandom) : {2'b00, 2'($urandom), 1'b0};
      rf = ($urandom_range(0, 3) == 0) ? 7'($urandom) : '0;
      tick("R9", 0, ra, 16'($urandom), 1'($urandom_range(0, 2) == 0), rf,
           ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0,
           ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0);
    end
    tick("R1", 1, '0, '0, 0, '0, '0, '0);
    rd("R1", 5'h00); rd("R1", 5'h02); rd("R1", 5'h04); rd("R1", 5'h06);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule